// File: doc/BRIEF.md
# Two-Road Intersection Signal Sequencer

The block runs the lamps of a crossing where a north-south road meets an east-west road. One direction holds right of way at a time: it shows green, then amber, then red, and the other direction takes over. Timing is counted in whole seconds from a strobe derived from the clock. The number of clock cycles in one second is a parameter, so a fast clock can stand in for real time.

Two vehicle-presence inputs, one per road, can change the fixed schedule. If a vehicle is still coming on the green road when its green runs out, and nothing waits on the red road, green is held for a further stretch once. If the red road has waited more than a minute, a vehicle is waiting there and nothing is coming on the green road, the green road goes to amber at once. Once the block commits to either choice it sees the choice through, whatever the inputs do next.

Top module: `traffic_light_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, north-south shows green and east-west shows red, whatever the vehicle inputs do.
- R2: Each road lights exactly one of its three lamps in every cycle, and exactly one road is not red.
- R3: With no vehicles, a green phase lasts `GREEN_SECS` (default 112) seconds, amber lasts `CAUTION_SECS` (default 8) seconds, and then the other road gets green. Each road holds right of way for two minutes.
- R4: Amber always lasts exactly `CAUTION_SECS` seconds. The road taking over stays red until that amber ends, then turns green in the next second.
- R5: If, in the last second of a green phase, the green road's input is high and the red road's input is low, green is held for `HOLD_SECS` (default 20) more seconds before amber.
- R6: A green phase is held at most once: when the hold runs out, amber follows even if the green road's input is still high.
- R7: During the unheld part of green, once the phase has run `RED_PATIENCE` (default 60) seconds or more, a high red-road input with a low green-road input sends the green road to amber in the next second.
- R8: No early change happens while green is younger than `RED_PATIENCE` seconds, or while the green road's input is also high.
- R9: During a hold and during amber the vehicle inputs have no effect on the lamps or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ns_car_seen | input | 1 | Vehicle approaching on the north-south road |
| ew_car_seen | input | 1 | Vehicle approaching on the east-west road |
| lamp_ns_red | output | 1 | North-south red lamp |
| lamp_ns_amber | output | 1 | North-south amber lamp |
| lamp_ns_green | output | 1 | North-south green lamp |
| lamp_ew_red | output | 1 | East-west red lamp |
| lamp_ew_amber | output | 1 | East-west amber lamp |
| lamp_ew_green | output | 1 | East-west green lamp |

## Verification
A run with no vehicles over more than one full two-road cycle fixes the baseline lengths of green and amber and the handover order. Holding the green road's input high across the end of green separates a granted hold from a plain end of phase. Keeping that input high through the hold, and raising the other road's input during the hold and during amber, shows that the hold happens once and that committed phases ignore the inputs. A waiting vehicle on the red road, first with and then without a competing vehicle on the green road, and also before the one-minute mark, separates the early change from the cases that must not trigger it. A final green phase with both inputs high shows that a red-road vehicle blocks the hold.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    // Phase of the road that currently holds right of way.
    typedef enum logic [1:0] {
        PH_GO      = 2'd0,
        PH_HOLD    = 2'd1,
        PH_CAUTION = 2'd2
    } phase_e;

    // Which road holds right of way.
    typedef enum logic {
        AX_NS = 1'b0,
        AX_EW = 1'b1
    } axis_e;

    localparam int unsigned NUM_ROADS = 2;

    typedef struct packed {
        logic red;
        logic amber;
        logic go;
    } lamp_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Lamp pattern for one road given the shared phase and whether it owns the crossing.
    function automatic lamp_t lamp_for(input phase_e ph, input logic owns);
        lamp_t l;
        l.red   = 1'b0;
        l.amber = 1'b0;
        l.go    = 1'b0;
        if (!owns) begin
            l.red = 1'b1;
        end else if (ph == PH_CAUTION) begin
            l.amber = 1'b1;
        end else begin
            l.go = 1'b1;
        end
        return l;
    endfunction

    function automatic axis_e other_axis(input axis_e a);
        return (a == AX_NS) ? AX_EW : AX_NS;
    endfunction

endpackage

// File: rtl/tlc_tick_gen.sv
module tlc_tick_gen #(
    parameter int unsigned CYCLES_PER_SEC = 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned DW   = (CYCLES_PER_SEC > 1) ? $clog2(CYCLES_PER_SEC) : 1;
    localparam int unsigned LAST = (CYCLES_PER_SEC > 1) ? CYCLES_PER_SEC - 1 : 0;

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_q == DW'(LAST)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == DW'(LAST));

endmodule

// File: rtl/tlc_sec_counter.sv
module tlc_sec_counter #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         restart,
    output logic [W-1:0] secs
);
    // Seconds spent in the current phase; saturates rather than wrapping.
    always_ff @(posedge clk) begin
        if (rst) begin
            secs <= '0;
        end else if (tick) begin
            if (restart) begin
                secs <= '0;
            end else if (secs != {W{1'b1}}) begin
                secs <= secs + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlc_sequencer.sv
module tlc_sequencer
    import tlc_pkg::*;
#(
    parameter int unsigned GREEN_SECS   = 112,
    parameter int unsigned HOLD_SECS    = 20,
    parameter int unsigned CAUTION_SECS = 8,
    parameter int unsigned RED_PATIENCE = 60,
    parameter int unsigned W            = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ns_car,
    input  logic         ew_car,
    input  logic [W-1:0] secs,
    output phase_e       phase,
    output axis_e        owner,
    output logic         restart
);
    logic   car_own;
    logic   car_other;
    logic   early_ok;
    phase_e phase_d;
    axis_e  owner_d;

    assign car_own   = (owner == AX_NS) ? ns_car : ew_car;
    assign car_other = (owner == AX_NS) ? ew_car : ns_car;

    // The red road has waited long enough, a vehicle waits there, none comes on green.
    assign early_ok = (secs >= W'(RED_PATIENCE)) && car_other && !car_own;

    always_comb begin
        phase_d = phase;
        owner_d = owner;
        restart = 1'b0;
        unique case (phase)
            PH_GO: begin
                if (early_ok) begin
                    phase_d = PH_CAUTION;
                    restart = 1'b1;
                end else if (secs == W'(GREEN_SECS - 1)) begin
                    restart = 1'b1;
                    phase_d = (car_own && !car_other) ? PH_HOLD : PH_CAUTION;
                end
            end
            PH_HOLD: begin
                // Committed: sensors are not looked at here.
                if (secs == W'(HOLD_SECS - 1)) begin
                    phase_d = PH_CAUTION;
                    restart = 1'b1;
                end
            end
            PH_CAUTION: begin
                if (secs == W'(CAUTION_SECS - 1)) begin
                    phase_d = PH_GO;
                    owner_d = other_axis(owner);
                    restart = 1'b1;
                end
            end
            default: begin
                phase_d = PH_GO;
                restart = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_GO;
            owner <= AX_NS;
        end else if (tick) begin
            phase <= phase_d;
            owner <= owner_d;
        end
    end

endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
    import tlc_pkg::*;
(
    input  phase_e                phase,
    input  axis_e                 owner,
    output lamp_t [NUM_ROADS-1:0] lamps
);
    for (genvar d = 0; d < NUM_ROADS; d++) begin : g_road
        localparam axis_e ME = (d == 0) ? AX_NS : AX_EW;
        assign lamps[d] = lamp_for(phase, owner == ME);
    end

endmodule

// File: rtl/traffic_light_ctrl.sv
module traffic_light_ctrl
    import tlc_pkg::*;
#(
    parameter int unsigned CYCLES_PER_SEC = 1,
    parameter int unsigned GREEN_SECS     = 112,
    parameter int unsigned HOLD_SECS      = 20,
    parameter int unsigned CAUTION_SECS   = 8,
    parameter int unsigned RED_PATIENCE   = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic ns_car_seen,
    input  logic ew_car_seen,
    output logic lamp_ns_red,
    output logic lamp_ns_amber,
    output logic lamp_ns_green,
    output logic lamp_ew_red,
    output logic lamp_ew_amber,
    output logic lamp_ew_green
);
    localparam int unsigned SEC_MAX =
        max_of(max_of(GREEN_SECS, HOLD_SECS), max_of(CAUTION_SECS, RED_PATIENCE));
    localparam int unsigned SEC_W = $clog2(SEC_MAX + 1);

    logic                  tick;
    logic                  restart;
    logic [SEC_W-1:0]      secs;
    phase_e                phase;
    axis_e                 owner;
    lamp_t [NUM_ROADS-1:0] lamps;

    tlc_tick_gen #(
        .CYCLES_PER_SEC(CYCLES_PER_SEC)
    ) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    tlc_sec_counter #(
        .W(SEC_W)
    ) u_secs (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .restart(restart),
        .secs   (secs)
    );

    tlc_sequencer #(
        .GREEN_SECS  (GREEN_SECS),
        .HOLD_SECS   (HOLD_SECS),
        .CAUTION_SECS(CAUTION_SECS),
        .RED_PATIENCE(RED_PATIENCE),
        .W           (SEC_W)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .ns_car (ns_car_seen),
        .ew_car (ew_car_seen),
        .secs   (secs),
        .phase  (phase),
        .owner  (owner),
        .restart(restart)
    );

    tlc_lamp_decode u_lamps (
        .phase(phase),
        .owner(owner),
        .lamps(lamps)
    );

    assign lamp_ns_red   = lamps[0].red;
    assign lamp_ns_amber = lamps[0].amber;
    assign lamp_ns_green = lamps[0].go;
    assign lamp_ew_red   = lamps[1].red;
    assign lamp_ew_amber = lamps[1].amber;
    assign lamp_ew_green = lamps[1].go;

endmodule

// File: rtl/tlc_checker.sv
module tlc_checker #(
    parameter int unsigned CAUTION_CYCLES   = 8,
    parameter int unsigned GREEN_MAX_CYCLES = 132
) (
    input logic clk,
    input logic rst,
    input logic ns_r,
    input logic ns_y,
    input logic ns_g,
    input logic ew_r,
    input logic ew_y,
    input logic ew_g
);
    localparam int unsigned AW = $clog2(CAUTION_CYCLES + 2);
    localparam int unsigned GW = $clog2(GREEN_MAX_CYCLES + 2);

    logic          rst_d;
    logic [AW-1:0] amber_run;
    logic [GW-1:0] green_run;
    logic          any_amber;
    logic          any_green;

    assign any_amber = ns_y | ew_y;
    assign any_green = ns_g | ew_g;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            amber_run <= '0;
            green_run <= '0;
        end else begin
            amber_run <= any_amber ? ((amber_run == {AW{1'b1}}) ? amber_run : amber_run + 1'b1) : '0;
            green_run <= any_green ? ((green_run == {GW{1'b1}}) ? green_run : green_run + 1'b1) : '0;
        end
    end

    // R1: the first cycle after reset shows north-south green, east-west red
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (ns_g && ew_r));

    // R2: one lamp per road
    a_r2_one_lamp_ns: assert property (@(posedge clk) disable iff (rst)
        $onehot({ns_r, ns_y, ns_g}));
    a_r2_one_lamp_ew: assert property (@(posedge clk) disable iff (rst)
        $onehot({ew_r, ew_y, ew_g}));

    // R2: exactly one road is not red
    a_r2_single_owner: assert property (@(posedge clk) disable iff (rst)
        $countones({ns_r, ew_r}) == 1);

    // R4: amber length
    a_r4_amber_len: assert property (@(posedge clk) disable iff (rst)
        $fell(any_amber) |-> (amber_run == AW'(CAUTION_CYCLES)));

    // R4: green is only gained straight after the other road's amber
    a_r4_handover_ew: assert property (@(posedge clk) disable iff (rst)
        $rose(ew_g) |-> $past(ns_y));
    a_r4_handover_ns: assert property (@(posedge clk) disable iff (rst)
        $rose(ns_g) |-> $past(ew_y));

    // R3: green never drops straight to red
    a_r3_green_to_amber: assert property (@(posedge clk) disable iff (rst)
        $fell(any_green) |-> any_amber);

    // R6: a green phase never runs past one hold
    a_r6_green_bounded: assert property (@(posedge clk) disable iff (rst)
        any_green |-> (green_run < GW'(GREEN_MAX_CYCLES)));

endmodule

bind traffic_light_ctrl tlc_checker #(
    .CAUTION_CYCLES  (CAUTION_SECS * CYCLES_PER_SEC),
    .GREEN_MAX_CYCLES((GREEN_SECS + HOLD_SECS) * CYCLES_PER_SEC)
) u_tlc_chk (
    .clk (clk),
    .rst (rst),
    .ns_r(lamp_ns_red),
    .ns_y(lamp_ns_amber),
    .ns_g(lamp_ns_green),
    .ew_r(lamp_ew_red),
    .ew_y(lamp_ew_amber),
    .ew_g(lamp_ew_green)
);

// File: tb/test_traffic_light_ctrl.sv
`timescale 1ns/1ps
module test_traffic_light_ctrl;

    localparam int G = 112;
    localparam int H = 20;
    localparam int Y = 8;
    localparam int P = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic car_ns = 1'b0;
    logic car_ew = 1'b0;
    logic ns_r, ns_y, ns_g, ew_r, ew_y, ew_g;

    always #2.5 clk = ~clk;

    traffic_light_ctrl i_traffic_light_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ns_car_seen  (car_ns),
        .ew_car_seen  (car_ew),
        .lamp_ns_red  (ns_r),
        .lamp_ns_amber(ns_y),
        .lamp_ns_green(ns_g),
        .lamp_ew_red  (ew_r),
        .lamp_ew_amber(ew_y),
        .lamp_ew_green(ew_g)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [5:0] q_lamps[$];
    string      q_tag[$];

    // Reference model: m_ph 0 green, 1 held green, 2 amber; m_dir 0 = NS owns.
    int m_dir, m_ph, m_left, m_age;

    function automatic logic [5:0] model_lamps();
        logic [2:0] own, oth;
        own = (m_ph == 2) ? 3'b010 : 3'b001;
        oth = 3'b100;
        return (m_dir == 0) ? {own, oth} : {oth, own};
    endfunction

    task automatic model_step(input logic cns, input logic cew);
        logic cg, cr;
        cg = (m_dir == 0) ? cns : cew;
        cr = (m_dir == 0) ? cew : cns;
        if (m_ph == 0) begin
            if (m_age >= P && cr && !cg) begin
                m_ph = 2; m_left = Y;
            end else if (m_left == 1) begin
                if (cg && !cr) begin m_ph = 1; m_left = H; end
                else begin m_ph = 2; m_left = Y; end
            end else begin
                m_left--; m_age++;
            end
        end else if (m_ph == 1) begin
            if (m_left == 1) begin m_ph = 2; m_left = Y; end
            else m_left--;
        end else begin
            if (m_left == 1) begin m_dir = 1 - m_dir; m_ph = 0; m_left = G; m_age = 0; end
            else m_left--;
        end
    endtask

    // Driver: applies one second of inputs and queues the lamps expected after the edge.
    task automatic drive(input logic cns, input logic cew, input string tag);
        car_ns = cns;
        car_ew = cew;
        model_step(cns, cew);
        q_lamps.push_back(model_lamps());
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // Inputs expressed per road role: own = green road, oth = red road.
    task automatic drive_role(input logic own, input logic oth, input string tag);
        if (m_dir == 0) drive(own, oth, tag);
        else            drive(oth, own, tag);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_lamps.size() > 0) begin
                logic [5:0] exp_l;
                string      t;
                exp_l = q_lamps.pop_front();
                t     = q_tag.pop_front();
                n_cmp++;
                if ({ns_r, ns_y, ns_g, ew_r, ew_y, ew_g} !== exp_l) begin
                    n_bad++;
                    $display("FAIL %s: lamps {ns ryg, ew ryg} got %b expected %b at %0t",
                             t, {ns_r, ns_y, ns_g, ew_r, ew_y, ew_g}, exp_l, $time);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state regardless of inputs
        car_ns = 1'b0;
        car_ew = 1'b1;
        repeat (4) @(negedge clk);
        n_cmp++;
        if ({ns_r, ns_y, ns_g, ew_r, ew_y, ew_g} !== 6'b001_100) begin
            n_bad++;
            $display("FAIL R1: lamps during reset got %b expected %b",
                     {ns_r, ns_y, ns_g, ew_r, ew_y, ew_g}, 6'b001_100);
        end
        m_dir = 0; m_ph = 0; m_left = G; m_age = 0;
        rst = 1'b0;
        drive(1'b0, 1'b1, "R1");

        // R2 R3 R4: no vehicles for more than a full cycle
        for (int i = 0; i < 260; i++) drive(1'b0, 1'b0, "R2 R3 R4");
        while (m_ph != 0 || m_age != 0) drive(1'b0, 1'b0, "R3");

        // R5: green road keeps a vehicle to the end of green
        while (m_ph == 0) drive_role(1'b1, 1'b0, "R5");
        // R6 and R9: hold runs out with the green-road vehicle still present,
        // a red-road vehicle appears during the hold
        for (int i = 0; m_ph == 1; i++) drive_role(1'b1, (i > 5), "R6 R9");
        // R9: amber ignores both inputs
        while (m_ph == 2) drive_role(1'b1, 1'b1, "R9");

        // R8: vehicles on both roads, past the one-minute mark, no early change
        for (int i = 0; i < 75; i++) drive_role(1'b1, 1'b1, "R8");
        // R7: green road clears, red road still waiting: amber next second
        while (m_ph == 0) drive_role(1'b0, 1'b1, "R7");
        while (m_ph == 2) drive_role(1'b0, 1'b0, "R4");

        // R8 then R7: red road waits from the start of green
        while (m_ph == 0 && m_age < P) drive_role(1'b0, 1'b1, "R8");
        while (m_ph == 0) drive_role(1'b0, 1'b1, "R7");
        while (m_ph == 2) drive_role(1'b1, 1'b0, "R9");

        // R5: a red-road vehicle blocks the hold, amber at the normal time
        while (m_ph == 0) drive_role(1'b1, 1'b1, "R5");
        while (m_ph == 2) drive_role(1'b0, 1'b0, "R4");
        for (int i = 0; i < 130; i++) drive(1'b0, 1'b0, "R3");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule